// File: doc/BRIEF.md
# Serial Flash Auto-Increment Program Engine

This block is the device-side command logic of a serial flash that answers a mode 0 SPI slave port. It decodes four commands: one that sets the write-enable latch, one that clears it, a status read, and an auto-increment byte program. The SPI pins are asynchronous to the system clock. They pass through synchronizers and are sampled there, so SCK must run well below the system clock.

The auto-increment program works in two steps. The first program frame carries an opcode, a 24-bit start address and one data byte. Once that frame has been accepted, the block stays in auto-increment mode across chip-select frames. Each later program frame carries only the opcode and one data byte, and that byte goes to the next sequential address. Every accepted byte becomes one write request (address, data) to an external memory interface, and the block stays busy until that interface returns a done pulse.

An upper protection boundary limits the address range. A start address above the boundary is refused. The address pointer never wraps: once the byte at the boundary address has been written, the mode ends and the write-enable latch is cleared.

Top module: `flash_aai_engine`

## Requirements
- R1: While chip select is low, MOSI is sampled on each rising SCK, most significant bit first, and every eight bits form one byte. Address bytes arrive high byte first.
- R2: A frame whose opcode is 0x06 sets the write-enable latch when chip select rises. The status byte carries BUSY at bit 0 and the latch at bit 1. All other status bits read 0.
- R3: After opcode 0x05, the status byte is driven on MISO most significant bit first, changing on falling SCK. Its first bit is valid before the ninth rising SCK. MISO is low while chip select is high.
- R4: Opcode 0xAF, sent while the latch is set, the mode is off and the block is not busy, followed by a 3-byte address and one data byte, issues exactly one single-cycle write request of that data at that address after chip select rises, and enters auto-increment mode.
- R5: In auto-increment mode, opcode 0xAF followed by one data byte writes that byte at the address one above the previous write.
- R6: An 0xAF frame received while the latch is clear, or while BUSY is set, has no effect: it issues no write and does not move the address pointer.
- R7: An 0xAF start address above TOP_ADDR issues no write and does not enter the mode. TOP_ADDR itself is writable.
- R8: Opcode 0x04 ends auto-increment mode and clears the latch, so a later 0xAF data-only frame writes nothing.
- R9: A frame that ends before a complete data byte has arrived issues no write and leaves the address pointer where it was.
- R10: Once the write at TOP_ADDR completes, the mode ends and the latch clears. The address does not wrap.
- R11: BUSY is set from the write request until the memory interface's done pulse.
- R12: After reset the latch, BUSY and the mode are clear, and no write request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | SPI data into the block |
| miso | output | 1 | SPI data out of the block (status) |
| wr_req | output | 1 | One-cycle byte write request |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 8 | Byte to be written |
| wr_done | input | 1 | Memory interface finished the write |

## Verification
The bench goes after the places where the pointer could go wrong:
- A short frame that stops after the opcode; a design that counted it would skip an address on the next write.
- A program frame sent during BUSY; a design that accepted it would issue a second write or advance the pointer.
- A protected start address, followed by a start address below the boundary. A design that entered the mode on the refused frame would read the following address bytes as data.
- A run up to the boundary, which must end the mode and clear the latch rather than wrap to zero.

Status reads check the bit order, the first-bit timing and that BUSY stays set for a long memory delay.

// File: rtl/aai_prog_pkg.sv
package aai_prog_pkg;
  localparam logic [7:0] OPC_LATCH_ON  = 8'h06;
  localparam logic [7:0] OPC_LATCH_OFF = 8'h04;
  localparam logic [7:0] OPC_STATUS    = 8'h05;
  localparam logic [7:0] OPC_AUTO_PGM  = 8'hAF;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_WEL_BIT  = 1;

  typedef enum logic [2:0] {
    FR_OPC,
    FR_ADDR,
    FR_DATA,
    FR_STAT,
    FR_SKIP
  } frame_st_t;
endpackage

// File: rtl/aai_spi_port.sv
module aai_spi_port #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              frame_begin,
  output logic              frame_end,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] cs_sr, sck_sr, si_sr;
  logic cs_q, sck_q, si_q, cs_prev, sck_prev;
  logic sck_rise, sck_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic              tx_armed;

  // input synchronizers
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sr    <= '1;
      sck_sr   <= '0;
      si_sr    <= '0;
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_sr    <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      sck_sr   <= {sck_sr[SYNC_STAGES-2:0], sck};
      si_sr    <= {si_sr[SYNC_STAGES-2:0], mosi};
      cs_prev  <= cs_q;
      sck_prev <= sck_q;
    end
  end

  assign cs_q     = cs_sr[SYNC_STAGES-1];
  assign sck_q    = sck_sr[SYNC_STAGES-1];
  assign si_q     = si_sr[SYNC_STAGES-1];
  assign sck_rise = sck_q & ~sck_prev & ~cs_q;
  assign sck_fall = ~sck_q & sck_prev & ~cs_q;

  // frame boundary pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_begin <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      frame_begin <= ~cs_q & cs_prev;
      frame_end   <= cs_q & ~cs_prev;
    end
  end

  // receive shifter, MSB first
  always_ff @(posedge clk) begin
    if (rst || cs_q) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (sck_rise) begin
      shreg   <= {shreg[BYTE_W-2:0], si_q};
      bit_cnt <= (bit_cnt == CNT_W'(BYTE_W-1)) ? '0 : bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_vld <= 1'b0;
      rx_byte  <= '0;
    end else begin
      byte_vld <= sck_rise && (bit_cnt == CNT_W'(BYTE_W-1));
      if (sck_rise && (bit_cnt == CNT_W'(BYTE_W-1)))
        rx_byte <= {shreg[BYTE_W-2:0], si_q};
    end
  end

  // transmit shifter: the falling edge that closes the opcode byte is skipped
  always_ff @(posedge clk) begin
    if (rst) begin
      txreg    <= '0;
      tx_armed <= 1'b0;
      miso     <= 1'b0;
    end else if (cs_q) begin
      txreg    <= '0;
      tx_armed <= 1'b0;
      miso     <= 1'b0;
    end else if (tx_load) begin
      txreg    <= tx_byte;
      miso     <= tx_byte[BYTE_W-1];
      tx_armed <= 1'b0;
    end else if (sck_fall) begin
      if (!tx_armed) begin
        tx_armed <= 1'b1;
      end else begin
        txreg <= {txreg[BYTE_W-2:0], 1'b0};
        miso  <= txreg[BYTE_W-2];
      end
    end
  end

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (cs_q && $past(cs_q)) |-> !miso);

  p_bitcnt_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> (bit_cnt == '0));
endmodule

// File: rtl/aai_seq_ctrl.sv
module aai_seq_ctrl
  import aai_prog_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                BYTE_W   = 8,
  parameter logic [ADDR_W-1:0] TOP_ADDR = 24'h07FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_begin,
  input  logic              frame_end,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              wr_done,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int ACNT_W     = $clog2(ADDR_BYTES + 1);

  frame_st_t         st;
  logic [7:0]        opc;
  logic [ADDR_W-1:0] addr_sh;
  logic [ACNT_W-1:0] abyte_cnt;
  logic [BYTE_W-1:0] dat_q;
  logic              dat_ok;
  logic              frm_first;
  logic              wel;
  logic              busy;
  logic              mode;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] status_now;

  always_comb begin
    status_now                = '0;
    status_now[STAT_BUSY_BIT] = busy;
    status_now[STAT_WEL_BIT]  = wel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FR_OPC;
      opc       <= '0;
      addr_sh   <= '0;
      abyte_cnt <= '0;
      dat_q     <= '0;
      dat_ok    <= 1'b0;
      frm_first <= 1'b0;
      wel       <= 1'b0;
      busy      <= 1'b0;
      mode      <= 1'b0;
      ptr       <= '0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      tx_load   <= 1'b0;
      tx_byte   <= '0;
    end else begin
      wr_req  <= 1'b0;
      tx_load <= 1'b0;

      // byte decoding within a frame
      if (frame_begin) begin
        st        <= FR_OPC;
        opc       <= '0;
        abyte_cnt <= '0;
        dat_ok    <= 1'b0;
        frm_first <= 1'b0;
      end else if (byte_vld) begin
        case (st)
          FR_OPC: begin
            opc <= rx_byte;
            if (rx_byte == OPC_AUTO_PGM) begin
              if (!wel || busy) begin
                st <= FR_SKIP;
              end else if (mode) begin
                st <= FR_DATA;
              end else begin
                st        <= FR_ADDR;
                frm_first <= 1'b1;
              end
            end else if (rx_byte == OPC_STATUS) begin
              st <= FR_STAT;
            end else begin
              st <= FR_SKIP;
            end
          end
          FR_ADDR: begin
            addr_sh   <= {addr_sh[ADDR_W-BYTE_W-1:0], rx_byte};
            abyte_cnt <= abyte_cnt + 1'b1;
            if (abyte_cnt == ACNT_W'(ADDR_BYTES-1)) st <= FR_DATA;
          end
          FR_DATA: begin
            dat_q  <= rx_byte;
            dat_ok <= 1'b1;
            st     <= FR_SKIP;
          end
          default: ;
        endcase
        if ((st == FR_OPC && rx_byte == OPC_STATUS) || st == FR_STAT) begin
          tx_load <= 1'b1;
          tx_byte <= status_now;
        end
      end

      // completion of a byte write: advance or leave at the boundary
      if (wr_done && busy) begin
        busy <= 1'b0;
        if (wr_addr == TOP_ADDR) begin
          mode <= 1'b0;
          wel  <= 1'b0;
        end else begin
          ptr <= wr_addr + 1'b1;
        end
      end

      // commands take effect when chip select rises
      if (frame_end) begin
        if (opc == OPC_LATCH_ON) begin
          wel <= 1'b1;
        end else if (opc == OPC_LATCH_OFF) begin
          wel  <= 1'b0;
          mode <= 1'b0;
        end
        if (dat_ok) begin
          if (frm_first) begin
            if (addr_sh <= TOP_ADDR) begin
              wr_req  <= 1'b1;
              wr_addr <= addr_sh;
              wr_data <= dat_q;
              busy    <= 1'b1;
              mode    <= 1'b1;
            end
          end else begin
            wr_req  <= 1'b1;
            wr_addr <= ptr;
            wr_data <= dat_q;
            busy    <= 1'b1;
          end
        end
        dat_ok <= 1'b0;
        opc    <= '0;
      end
    end
  end

  p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req);

  p_req_range_r7: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (wr_addr <= TOP_ADDR));

  p_req_idle_r6: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> !$past(busy));

  p_req_wel_r6: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> wel);

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_done) |=> busy);

  p_top_exit_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_done && busy && wr_addr == TOP_ADDR && !frame_end) |=> (!mode && !wel));
endmodule

// File: rtl/flash_aai_engine.sv
module flash_aai_engine #(
  parameter int                ADDR_W      = 24,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] TOP_ADDR    = 24'h07FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_done
);
  localparam int BYTE_W = 8;

  logic              frame_begin, frame_end, byte_vld, tx_load;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  aai_spi_port #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_W     (BYTE_W)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sck        (sck),
    .mosi       (mosi),
    .tx_load    (tx_load),
    .tx_byte    (tx_byte),
    .frame_begin(frame_begin),
    .frame_end  (frame_end),
    .byte_vld   (byte_vld),
    .rx_byte    (rx_byte),
    .miso       (miso)
  );

  aai_seq_ctrl #(
    .ADDR_W  (ADDR_W),
    .BYTE_W  (BYTE_W),
    .TOP_ADDR(TOP_ADDR)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frame_begin(frame_begin),
    .frame_end  (frame_end),
    .byte_vld   (byte_vld),
    .rx_byte    (rx_byte),
    .wr_done    (wr_done),
    .tx_load    (tx_load),
    .tx_byte    (tx_byte),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );
endmodule

// File: tb/flash_aai_engine_test.sv
`timescale 1ns/100ps
module flash_aai_engine_test;
  localparam logic [23:0] TOP = 24'h000FFF;
  localparam int H  = 8;
  localparam int NV = 14;

  // {frame bytes left aligned, byte count, write expected, address, data}
  localparam logic [75:0] VEC [NV] = '{
    {40'hAF00001055, 3'd5, 1'b0, 24'h000000, 8'h00},
    {40'h0600000000, 3'd1, 1'b0, 24'h000000, 8'h00},
    {40'hAF00001055, 3'd5, 1'b1, 24'h000010, 8'h55},
    {40'hAFA1000000, 3'd2, 1'b1, 24'h000011, 8'hA1},
    {40'hAF22000000, 3'd2, 1'b1, 24'h000012, 8'h22},
    {40'hAF00000000, 3'd1, 1'b0, 24'h000000, 8'h00},
    {40'hAF33000000, 3'd2, 1'b1, 24'h000013, 8'h33},
    {40'h0400000000, 3'd1, 1'b0, 24'h000000, 8'h00},
    {40'hAF44000000, 3'd2, 1'b0, 24'h000000, 8'h00},
    {40'h0600000000, 3'd1, 1'b0, 24'h000000, 8'h00},
    {40'hAF00100077, 3'd5, 1'b0, 24'h000000, 8'h00},
    {40'hAF000FFE01, 3'd5, 1'b1, 24'h000FFE, 8'h01},
    {40'hAF02000000, 3'd2, 1'b1, 24'h000FFF, 8'h02},
    {40'hAF03000000, 3'd2, 1'b0, 24'h000000, 8'h00}
  };
  localparam string VREQ [NV] = '{
    "R6", "R2", "R4", "R5", "R5", "R9", "R9",
    "R8", "R8", "R2", "R7", "R7", "R10", "R10"
  };

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wr_done = 1'b0;
  logic        miso, wr_req;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;

  int n_tests = 0, n_fail = 0;
  int mem_delay = 4, wr_cnt = 0, dly_cnt = 0;
  logic pend = 1'b0;
  logic [23:0] last_a = '0;
  logic [7:0]  last_d = '0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_aai_engine #(.TOP_ADDR(TOP)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done)
  );

  // memory interface model
  always @(posedge clk) begin
    wr_done <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else if (wr_req) begin
      wr_cnt  <= wr_cnt + 1;
      last_a  <= wr_addr;
      last_d  <= wr_data;
      pend    <= 1'b1;
      dly_cnt <= mem_delay;
    end else if (pend) begin
      if (dly_cnt == 0) begin
        wr_done <= 1'b1;
        pend    <= 1'b0;
      end else begin
        dly_cnt <= dly_cnt - 1;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      wait_clk(H);
      r[i] = miso;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [39:0] b, input int n);
    logic [7:0] d;
    cs_n = 1'b0;
    wait_clk(H);
    for (int k = 0; k < n; k++) xfer(b[39-8*k -: 8], d);
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(4*H);
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_n = 1'b0;
    wait_clk(H);
    xfer(8'h05, d);
    xfer(8'h00, s);
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(4*H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int c0;
    wait_clk(5);
    check(wr_req == 1'b0 && miso == 1'b0, "R12", "outputs in reset", {wr_req, miso}, 0);
    rst = 1'b0;
    wait_clk(5);
    check(wr_req == 1'b0 && miso == 1'b0, "R12", "outputs after reset", {wr_req, miso}, 0);
    rdsr(s);
    check(s == 8'h00, "R12", "status after reset", s, 8'h00);

    for (int v = 0; v < NV; v++) begin
      c0 = wr_cnt;
      send(VEC[v][75:36], int'(VEC[v][35:33]));
      wait_clk(60);
      check((wr_cnt - c0) == (VEC[v][32] ? 1 : 0), VREQ[v], $sformatf("vector %0d write count", v),
            wr_cnt - c0, VEC[v][32] ? 1 : 0);
      if (VEC[v][32]) begin
        check(last_a == VEC[v][31:8], VREQ[v], $sformatf("vector %0d address (R1)", v),
              last_a, VEC[v][31:8]);
        check(last_d == VEC[v][7:0], VREQ[v], $sformatf("vector %0d data (R1)", v),
              last_d, VEC[v][7:0]);
      end
    end

    rdsr(s);
    check(s == 8'h00, "R10", "latch cleared at boundary", s, 8'h00);
    send(40'h0600000000, 1);
    rdsr(s);
    check(s == 8'h02, "R2", "latch bit 1 set", s, 8'h02);

    // long write: BUSY visible, program frame ignored while busy
    mem_delay = 3000;
    c0 = wr_cnt;
    send(40'hAF000200AA, 5);
    wait_clk(20);
    rdsr(s);
    check(s == 8'h03, "R11", "busy during write (R3 R1 bit order)", s, 8'h03);
    send(40'hAFBB000000, 2);
    wait_clk(3200);
    check((wr_cnt - c0) == 1, "R6", "frame during busy ignored", wr_cnt - c0, 1);
    check(last_a == 24'h000200 && last_d == 8'hAA, "R4", "first write", {last_d, last_a},
          {8'hAA, 24'h000200});
    rdsr(s);
    check(s == 8'h02, "R11", "busy cleared by done", s, 8'h02);
    mem_delay = 4;
    send(40'hAFCC000000, 2);
    wait_clk(60);
    check(last_a == 24'h000201 && last_d == 8'hCC, "R5", "pointer not moved by busy frame",
          {last_d, last_a}, {8'hCC, 24'h000201});
    send(40'h0400000000, 1);
    rdsr(s);
    check(s == 8'h00, "R8", "latch off ends mode", s, 8'h00);
    check(miso == 1'b0, "R3", "miso idle", miso, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule